// File: doc/BRIEF.md
# Timestamp-Driven Playout Rate Tracker

This block sits at the receiving end of a stream whose samples arrive in bursts. Each incoming sample is written into an elastic buffer. Some samples carry a sender timestamp, typically one sample in every eight. A numerically controlled oscillator (a phase accumulator) sets the playout rate, and every carry out of the accumulator reads one sample out of the buffer.

When a sample that carries a timestamp leaves the buffer, the block subtracts that timestamp from the local time count at the same instant. The difference is clipped and passed through a proportional-integral filter with shift-only gains, and the filter sets a new oscillator increment. The buffer fill never steers the rate, so the pattern in which samples arrive does not disturb the output rate. The buffer only has to be deep enough to absorb the bursts.

Playout waits until a programmable number of samples has been buffered. After that it runs on every oscillator carry. If a carry finds the buffer empty, a sticky underflow flag is set and the output sample is held.

Top module: `rt_playout_tracker`

## Requirements
- R1: While reset is asserted and directly after it, out_valid and out_data are 0, underflow is 0, and freq_word equals the nominal increment NOM_INC (default 8192).
- R2: No sample is played while the registered buffer count is below start_level. Playout is enabled on the first clock edge at which the count is at least start_level. Once enabled, it stays enabled whatever the fill until the next reset.
- R3: While playout is enabled, a PW-bit phase accumulator adds freq_word every cycle. A carry out pops the oldest buffered sample in arrival order. out_valid is high for exactly the one cycle after that edge, and out_data shows the popped sample.
- R4: A written sample with in_has_ts high stores in_ts beside it. On the pop of such a sample, the error is local_time minus the stored timestamp, computed modulo 2^TW, read as a signed value and clipped to ±ERR_LIM (default 64). The subtraction is correct across a wrap of the time counters.
- R5: On each pop of a timestamped sample, the integrator adds the clipped error. freq_word becomes NOM_INC + floor(integrator / 2^KI_SH) + floor(error / 2^KP_SH), saturated to 0..2^PW-1, with defaults KI_SH=6 and KP_SH=2. The new value appears on the same edge at which out_valid rises.
- R6: freq_word does not change on a pop of a sample without a timestamp, on writes, or because of the buffer fill.
- R7: An accumulator carry while playout is enabled and the buffer is empty sets underflow. underflow stays set until reset, out_valid stays low, and out_data keeps its last value.
- R8: A write while the buffer holds DEPTH samples (default 32) is discarded, together with its timestamp. The discarded sample never appears at the output.
- R9: A write and a pop in the same cycle both take effect. Samples arriving in bursts keep their order and timestamp association through simultaneous writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write one sample this cycle |
| in_data | input | DW | Sample value |
| in_has_ts | input | 1 | This sample carries a timestamp |
| in_ts | input | TW | Sender timestamp for this sample |
| local_time | input | TW | Local copy of the time count |
| start_level | input | $clog2(DEPTH)+1 | Fill at which playout starts |
| out_valid | output | 1 | One-cycle pulse per played sample |
| out_data | output | DW | Last played sample |
| underflow | output | 1 | Sticky: a carry found the buffer empty |
| freq_word | output | PW | Current oscillator increment |

## Verification
The two functions that most easily fall in the same cycle are a buffer write and an oscillator-driven pop. Writes come in random bursts whose average rate matches the nominal playout rate, so a pop regularly lands in a cycle that also writes. The directed cases go further: a timestamp is written in the same cycle as another timestamped sample is read, and a write arrives into a full buffer.

Every such cycle is judged against a bench model built from the requirements. The model predicts the played value, the order of samples and the freq_word update. Underflow and full-buffer drops are provoked on purpose and judged through what later reaches the output.

// File: rtl/rt_pkg.sv
package rt_pkg;

    // Symmetric clip of a signed time error.
    function automatic int clamp_err(input int v, input int lim);
        if (v > lim)  return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

endpackage

// File: rtl/rt_fifo.sv
module rt_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               wr_data,
    output logic [W-1:0]               rd_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       empty,
    output logic                       full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt == CW'(DEPTH));
    assign count   = s_q.cnt;
    assign rd_data = mem_q[s_q.rp];
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wp = s_q.wp + 1'b1;
        if (do_pop)  s_d.rp = s_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= wr_data;
    end

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH)); // R8
    AST_FULL_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (s_q.cnt == CW'(DEPTH))); // R8

endmodule

// File: rtl/rt_loop.sv
module rt_loop #(
    parameter int PW      = 16,
    parameter int NOM_INC = 8192,
    parameter int KP_SH   = 2,
    parameter int KI_SH   = 6,
    parameter int IW      = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               upd,
    input  logic signed [31:0] err,
    output logic               tick,
    output logic [PW-1:0]      inc
);
    localparam int SW = IW + 2;
    localparam logic signed [SW-1:0] INC_MAX = SW'((2 ** PW) - 1);

    typedef struct packed {
        logic [PW-1:0]        phase;
        logic [PW-1:0]        inc;
        logic signed [IW-1:0] integ;
    } loop_state_t;

    loop_state_t s_d, s_q;
    logic [PW:0]          sum;
    logic signed [SW-1:0] raw;

    assign sum  = {1'b0, s_q.phase} + {1'b0, s_q.inc};
    assign tick = run & sum[PW];
    assign inc  = s_q.inc;

    always_comb begin
        s_d = s_q;
        raw = '0;
        if (run) s_d.phase = sum[PW-1:0];
        if (upd) begin
            s_d.integ = s_q.integ + IW'(err);
            raw = SW'(NOM_INC) + SW'(s_d.integ >>> KI_SH) + SW'(err >>> KP_SH);
            if (raw < 0)            s_d.inc = '0;
            else if (raw > INC_MAX) s_d.inc = '1;
            else                    s_d.inc = raw[PW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= '0;
            s_q.inc   <= PW'(NOM_INC);
            s_q.integ <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_FREQ_ONLY_ON_TS: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(s_q.inc)); // R6
    AST_PHASE_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(s_q.phase)); // R2

endmodule

// File: rtl/rt_playout_tracker.sv
module rt_playout_tracker #(
    parameter int DW      = 8,
    parameter int TW      = 32,
    parameter int DEPTH   = 32,
    parameter int PW      = 16,
    parameter int NOM_INC = 8192,
    parameter int KP_SH   = 2,
    parameter int KI_SH   = 6,
    parameter int IW      = 24,
    parameter int ERR_LIM = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [DW-1:0]             in_data,
    input  logic                      in_has_ts,
    input  logic [TW-1:0]             in_ts,
    input  logic [TW-1:0]             local_time,
    input  logic [$clog2(DEPTH):0]    start_level,
    output logic                      out_valid,
    output logic [DW-1:0]             out_data,
    output logic                      underflow,
    output logic [PW-1:0]             freq_word
);
    import rt_pkg::*;

    localparam int CW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic          running;
        logic          ovalid;
        logic [DW-1:0] odata;
        logic          uflow;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [DW:0]     smp_head;
    logic [CW-1:0]   smp_cnt, ts_cnt;
    logic            smp_empty, smp_full, ts_empty, ts_full;
    logic [TW-1:0]   ts_head, tdiff;
    logic            push_s, push_t, pop_s, pop_t, tick;
    logic signed [31:0] err;

    assign push_s = in_valid & ~smp_full;
    assign push_t = push_s & in_has_ts;
    assign pop_s  = tick & ~smp_empty;
    assign pop_t  = pop_s & smp_head[DW];
    assign tdiff  = local_time - ts_head;
    assign err    = clamp_err(int'($signed(tdiff)), ERR_LIM);

    rt_fifo #(.W(DW + 1), .DEPTH(DEPTH)) i_smp_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_s), .pop(pop_s),
        .wr_data({in_has_ts, in_data}), .rd_data(smp_head),
        .count(smp_cnt), .empty(smp_empty), .full(smp_full)
    );

    rt_fifo #(.W(TW), .DEPTH(DEPTH)) i_ts_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_t), .pop(pop_t),
        .wr_data(in_ts), .rd_data(ts_head),
        .count(ts_cnt), .empty(ts_empty), .full(ts_full)
    );

    rt_loop #(.PW(PW), .NOM_INC(NOM_INC), .KP_SH(KP_SH), .KI_SH(KI_SH), .IW(IW)) i_loop (
        .clk(clk), .rst_n(rst_n), .run(s_q.running), .upd(pop_t),
        .err(err), .tick(tick), .inc(freq_word)
    );

    always_comb begin
        s_d         = s_q;
        s_d.running = s_q.running | (smp_cnt >= start_level);
        s_d.ovalid  = pop_s;
        if (pop_s) s_d.odata = smp_head[DW-1:0];
        if (tick && smp_empty) s_d.uflow = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.ovalid;
    assign out_data  = s_q.odata;
    assign underflow = s_q.uflow;

    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.running |=> !out_valid); // R2
    AST_TS_BEHIND_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        ts_cnt <= smp_cnt); // R4
    AST_TS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        pop_t |-> !ts_empty); // R4
    AST_TS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push_t |-> !ts_full); // R8
    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow); // R7
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data)); // R7

endmodule

// File: tb/test_rt_playout_tracker.sv
module test_rt_playout_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8, TW = 32, DEPTH = 32, PW = 16;
    localparam int NOM = 8192, KP = 2, KI = 6, LIM = 64;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_has_ts = 0;
    logic [DW-1:0] in_data = '0;
    logic [TW-1:0] in_ts = '0, local_time = '0;
    logic [5:0] start_level = '0;
    logic out_valid, underflow;
    logic [DW-1:0] out_data;
    logic [PW-1:0] freq_word;

    int nchk = 0, nfail = 0;
    bit done = 0;

    // reference model state
    bit m_run, m_ov, m_uf;
    int unsigned m_phase, m_inc, m_od, lt;
    int m_integ;
    int qd[$], qf[$];
    int unsigned qt[$];
    string tag_o, tag_f;
    int nval;
    int unsigned last_val;

    rt_playout_tracker i_rt_playout_tracker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_has_ts(in_has_ts), .in_ts(in_ts), .local_time(local_time),
        .start_level(start_level), .out_valid(out_valid), .out_data(out_data),
        .underflow(underflow), .freq_word(freq_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int clip(int v);
        if (v > LIM) return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    function automatic int unsigned next_inc(int e);
        int raw;
        raw = NOM + (m_integ >>> KI) + (e >>> KP);
        if (raw < 0) return 0;
        if (raw > 65535) return 65535;
        return raw;
    endfunction

    task automatic model_reset();
        m_run = 0; m_ov = 0; m_uf = 0; m_phase = 0; m_inc = NOM; m_od = 0; m_integ = 0;
        qd.delete(); qf.delete(); qt.delete();
    endtask

    task automatic model_step(bit iv, int id, bit ih, int unsigned its);
        int cnt; bit push, tick, pop; int unsigned sum; int e;
        cnt = qd.size();
        push = iv && (cnt < DEPTH);
        sum = m_phase + m_inc;
        tick = m_run && (sum >= 65536);
        pop = tick && (cnt > 0);
        if (m_run) m_phase = sum & 16'hFFFF;
        m_run = m_run || (cnt >= int'(start_level));
        tag_o = m_run ? "R3" : "R2";
        tag_f = "R6";
        if (pop) begin
            m_ov = 1; m_od = qd[0];
            if (qf[0] != 0) begin
                e = clip(int'(lt - qt[0]));
                m_integ += e;
                m_inc = next_inc(e);
                tag_o = "R4"; tag_f = "R5";
            end
            void'(qd.pop_front()); void'(qf.pop_front()); void'(qt.pop_front());
            if (push) tag_o = "R9";
        end else begin
            m_ov = 0;
            if (tick && cnt == 0) begin m_uf = 1; tag_o = "R7"; end
        end
        if (push) begin qd.push_back(id); qf.push_back(int'(ih)); qt.push_back(its); end
    endtask

    task automatic cycle(bit iv, int id, bit ih, int unsigned its);
        @(negedge clk);
        lt = lt + 1;
        local_time = lt; in_valid = iv; in_data = DW'(id); in_has_ts = ih; in_ts = its;
        model_step(iv, id, ih, its);
        @(posedge clk); #1;
        chk({tag_o, " out_valid"}, out_valid, m_ov);
        chk({tag_o, " out_data"}, out_data, m_od);
        chk({tag_f, " freq_word"}, freq_word, m_inc);
        chk("R7 underflow", underflow, m_uf);
        if (out_valid) begin nval++; last_val = out_data; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; in_has_ts = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 out_valid in reset", out_valid, 0);
        chk("R1 freq_word in reset", freq_word, NOM);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        @(posedge clk); #1;
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_data", out_data, 0);
        chk("R1 underflow", underflow, 0);
        chk("R1 freq_word", freq_word, NOM);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int k;
        void'($urandom(32'd1234));
        lt = 1000;
        start_level = 6'd12;
        do_reset();

        // R2: eleven samples, then a long wait with no playout
        k = 0;
        for (int i = 0; i < 11; i++) begin
            cycle(1, k, (k % 8) == 0, lt + 90 + $urandom_range(0, 40));
            k++;
            repeat ($urandom_range(0, 3)) cycle(0, 0, 0, 0);
        end
        nval = 0;
        repeat (60) cycle(0, 0, 0, 0);
        chk("R2 no play below start level", nval, 0);
        cycle(1, k, 0, 0); k++;

        // R3..R6, R9: bursty arrivals at nominal average rate
        for (int w = 0; w < 60; w++) begin
            int st;
            st = $urandom_range(0, 40);
            for (int c = 0; c < 64; c++) begin
                if (c >= st && c < st + 8) begin
                    cycle(1, k & 8'hFF, (k % 8) == 0, lt + 60 + $urandom_range(0, 200));
                    k++;
                end else cycle(0, 0, 0, 0);
            end
        end

        // R4: time counters wrapping
        lt = 32'hFFFF_FFE0;
        for (int i = 0; i < 8; i++) begin
            cycle(1, 8'hA0 + i, 1, lt + 20 + i);
            repeat (7) cycle(0, 0, 0, 0);
        end

        // R7: starve the buffer
        repeat (400) cycle(0, 0, 0, 0);
        chk("R7 underflow set after starving", underflow, 1);
        nval = 0;
        repeat (40) cycle(0, 0, 0, 0);
        chk("R7 no output while empty", nval, 0);

        // R8: overfill, then drain
        start_level = 6'd32;
        do_reset();
        nval = 0;
        for (int i = 0; i < 40; i++) cycle(1, i, (i % 8) == 0, lt + 300);
        repeat (400) cycle(0, 0, 0, 0);
        chk("R8 samples played after overfill", nval, 32);
        chk("R8 last played sample", last_val, 31);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule